// File: doc/BRIEF.md
# Byte-Align Register Unit

This unit executes one media instruction: it joins two 32-bit registers into an eight-byte string and keeps four consecutive bytes from that string. The window's start position comes from a 3-bit offset field in the instruction word. The unit holds sixteen extended registers. Index 0 is wired to zero: it reads as zero and cannot be written.

Each instruction is given as a 32-bit word with a one-cycle valid strobe. The unit decodes the word and drops any word it does not own, any word with non-zero padding and any word with a reserved offset. For a legal word it writes the selected window to the destination register at the same clock edge.

A debug port reads any register at any time. A second debug port writes a register, which is how registers are preloaded. An instruction that offers a reserved offset drives a status flag high for one cycle.

Top module: `bytealign_regunit`

## Requirements
- R1: A word is executed only when `insn_valid` is high, bits 31:26 equal 6'b011100 and bits 5:0 equal the `MINOR_OP` parameter (default 6'h2F). Any other word, and any word presented with `insn_valid` low, changes no register and does not raise the flag.
- R2: The fields sit at fixed positions in the word:
  - offset: bits 25:23
  - pad: bits 22:21
  - low-source index: bits 17:14
  - high-source index: bits 13:10
  - destination index: bits 9:6

  Bits 20:18 are ignored. Only the destination register changes.
- R3: A matching word with a non-zero pad field is a silent no-op: no register changes and the flag stays low.
- R4: Destination index 0 writes nothing. Register 0 reads as zero on the debug port at all times, including after a debug write to it.
- R5: A source index of 0 supplies the value 0x00000000.
- R6: The string is {high source, low source}, with the most significant byte at position 0. Offset k, for k from 0 to 4, yields the four bytes at positions k to k+3. Offset 0 returns the high source unchanged and offset 4 returns the low source unchanged.
- R7: Offsets 1, 2 and 3 yield `(hi<<8)|(lo>>24)`, `(hi<<16)|(lo>>16)` and `(hi<<24)|(lo>>8)` respectively.
- R8: When both source indices are the same register, offsets 1 to 3 yield that register rotated left by 8 times the offset.
- R9: Offsets 5, 6 and 7 on an otherwise legal word write nothing. `rsvd_flag` is high in exactly the clock cycle that follows the word's cycle.
- R10: A write is visible on `dbg_rdata` right after the clock edge that samples the valid word. A synchronous active-high `rst` clears every register and `rsvd_flag`.
- R11: `dbg_we` writes `dbg_wdata` to register `dbg_widx` at the clock edge. If an instruction writes the same register in the same cycle, the instruction's value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| insn_valid | input | 1 | Instruction word strobe |
| insn_word | input | 32 | Instruction word |
| dbg_we | input | 1 | Debug write enable |
| dbg_widx | input | 4 | Debug write register index |
| dbg_wdata | input | 32 | Debug write data |
| dbg_ridx | input | 4 | Debug read register index |
| dbg_rdata | output | 32 | Debug read data (combinational) |
| rsvd_flag | output | 1 | One-cycle pulse after a reserved offset |

## Verification
The source registers are preloaded with distinct, byte-asymmetric values and the funnel is swept across all five legal offsets. Because every byte is different, a window that starts one byte off, or bytes taken from the wrong source, shows up at once. The following cases are each run separately:
- the same register as both sources, which separates a true rotate from a shift that fills with zeros;
- one zero source and then the other, which shows which half of the string each index feeds;
- both sources zero.

Words that must do nothing (wrong opcode, non-zero pad, reserved offset, destination 0, valid low) are each followed by a comparison of all sixteen registers, and for the reserved offsets by a check that the flag is a single pulse.

// File: rtl/bytealign_pkg.sv
package bytealign_pkg;

   localparam int unsigned INSN_W    = 32;
   localparam int unsigned REG_IDX_W = 4;
   localparam int unsigned OFF_W     = 3;
   localparam int unsigned PAD_W     = 2;
   localparam int unsigned OPC_W     = 6;

   localparam logic [OPC_W-1:0] MAJOR_GRP = 6'b011100;

   localparam int unsigned MAJOR_LSB = 26;
   localparam int unsigned OFF_LSB   = 23;
   localparam int unsigned PAD_LSB   = 21;
   localparam int unsigned LO_LSB    = 14;
   localparam int unsigned HI_LSB    = 10;
   localparam int unsigned DST_LSB   = 6;
   localparam int unsigned MINOR_LSB = 0;

   typedef struct packed {
      logic [OPC_W-1:0]     major;
      logic [OFF_W-1:0]     offset;
      logic [PAD_W-1:0]     pad;
      logic [REG_IDX_W-1:0] lo_idx;
      logic [REG_IDX_W-1:0] hi_idx;
      logic [REG_IDX_W-1:0] dst_idx;
      logic [OPC_W-1:0]     minor;
   } ba_fields_t;

endpackage

// File: rtl/bytealign_decode.sv
module bytealign_decode
   import bytealign_pkg::*;
#(
   parameter int unsigned      LANES    = 4,
   parameter logic [OPC_W-1:0] MINOR_OP = 6'h2F
) (
   input  logic              insn_valid,
   input  logic [INSN_W-1:0] insn_word,
   output ba_fields_t        fld,
   output logic              hit,
   output logic              wr_en,
   output logic              rsvd_hit
);

   logic pad_ok;
   logic off_ok;
   logic unused_gap;

   assign fld.major   = insn_word[MAJOR_LSB +: OPC_W];
   assign fld.offset  = insn_word[OFF_LSB   +: OFF_W];
   assign fld.pad     = insn_word[PAD_LSB   +: PAD_W];
   assign fld.lo_idx  = insn_word[LO_LSB    +: REG_IDX_W];
   assign fld.hi_idx  = insn_word[HI_LSB    +: REG_IDX_W];
   assign fld.dst_idx = insn_word[DST_LSB   +: REG_IDX_W];
   assign fld.minor   = insn_word[MINOR_LSB +: OPC_W];
   assign unused_gap  = ^insn_word[LO_LSB+REG_IDX_W +: 3];

   assign hit      = insn_valid && (fld.major == MAJOR_GRP) && (fld.minor == MINOR_OP);
   assign pad_ok   = (fld.pad == '0);
   assign off_ok   = (32'(fld.offset) <= LANES);
   assign wr_en    = hit && pad_ok && off_ok && (fld.dst_idx != '0);
   assign rsvd_hit = hit && pad_ok && !off_ok;

endmodule

// File: rtl/bytealign_funnel.sv
module bytealign_funnel
   import bytealign_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] hi_data,
   input  logic [DATA_W-1:0] lo_data,
   input  logic [OFF_W-1:0]  offset,
   output logic [DATA_W-1:0] window
);

   localparam int unsigned LANES = DATA_W / 8;
   localparam int unsigned CAT_W = 2 * DATA_W;

   logic [CAT_W-1:0]  joined;
   logic [DATA_W-1:0] cand [LANES+1];

   assign joined = {hi_data, lo_data};

   for (genvar k = 0; k <= LANES; k++) begin : g_cand
      if (k == 0) begin : g_edge_hi
         assign cand[k] = hi_data;
      end else if (k == LANES) begin : g_edge_lo
         assign cand[k] = lo_data;
      end else begin : g_mid
         assign cand[k] = joined[CAT_W-1-8*k -: DATA_W];
      end
   end

   always_comb begin
      window = '0;
      for (int k = 0; k <= LANES; k++) begin
         if (offset == OFF_W'(k)) window = cand[k];
      end
   end

endmodule

// File: rtl/bytealign_regfile.sv
module bytealign_regfile
   import bytealign_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [REG_IDX_W-1:0] a_idx,
   input  logic [REG_IDX_W-1:0] b_idx,
   output logic [DATA_W-1:0]    a_data,
   output logic [DATA_W-1:0]    b_data,
   input  logic                 we,
   input  logic [REG_IDX_W-1:0] widx,
   input  logic [DATA_W-1:0]    wdata,
   input  logic                 dbg_we,
   input  logic [REG_IDX_W-1:0] dbg_widx,
   input  logic [DATA_W-1:0]    dbg_wdata,
   input  logic [REG_IDX_W-1:0] dbg_ridx,
   output logic [DATA_W-1:0]    dbg_rdata
);

   localparam int unsigned NREG = 1 << REG_IDX_W;

   logic [DATA_W-1:0] mem_q [NREG];

   function automatic logic [DATA_W-1:0] rd(input logic [REG_IDX_W-1:0] idx,
                                            input logic [DATA_W-1:0] entry);
      return (idx == '0) ? '0 : entry;
   endfunction

   assign a_data    = rd(a_idx,    mem_q[a_idx]);
   assign b_data    = rd(b_idx,    mem_q[b_idx]);
   assign dbg_rdata = rd(dbg_ridx, mem_q[dbg_ridx]);

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
      end else begin
         if (dbg_we && dbg_widx != '0) mem_q[dbg_widx] <= dbg_wdata;
         if (we && widx != '0)         mem_q[widx]     <= wdata;
      end
   end

   assert_src_zero_R5: assert property (@(posedge clk) disable iff (rst)
      (a_idx == '0) |-> (a_data == '0));

   assert_reg0_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (dbg_ridx == '0) |-> (dbg_rdata == '0));

   assert_write_lands_R10: assert property (@(posedge clk) disable iff (rst)
      (we && widx != '0) |=> (mem_q[$past(widx)] == $past(wdata)));

endmodule

// File: rtl/bytealign_regunit.sv
module bytealign_regunit
   import bytealign_pkg::*;
#(
   parameter int unsigned      DATA_W   = 32,
   parameter logic [OPC_W-1:0] MINOR_OP = 6'h2F
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 insn_valid,
   input  logic [INSN_W-1:0]    insn_word,
   input  logic                 dbg_we,
   input  logic [REG_IDX_W-1:0] dbg_widx,
   input  logic [DATA_W-1:0]    dbg_wdata,
   input  logic [REG_IDX_W-1:0] dbg_ridx,
   output logic [DATA_W-1:0]    dbg_rdata,
   output logic                 rsvd_flag
);

   localparam int unsigned LANES = DATA_W / 8;

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of bytes");
   end
   if (LANES < 2 || LANES >= (1 << OFF_W)) begin : g_bad_lanes
      $error("byte lane count must fit the offset field");
   end

   ba_fields_t        fld;
   logic              hit;
   logic              inst_we;
   logic              rsvd_hit;
   logic [DATA_W-1:0] hi_data;
   logic [DATA_W-1:0] lo_data;
   logic [DATA_W-1:0] window;
   logic              rsvd_q;

   bytealign_decode #(.LANES(LANES), .MINOR_OP(MINOR_OP)) u_dec (
      .insn_valid (insn_valid),
      .insn_word  (insn_word),
      .fld        (fld),
      .hit        (hit),
      .wr_en      (inst_we),
      .rsvd_hit   (rsvd_hit)
   );

   bytealign_regfile #(.DATA_W(DATA_W)) u_rf (
      .clk       (clk),
      .rst       (rst),
      .a_idx     (fld.hi_idx),
      .b_idx     (fld.lo_idx),
      .a_data    (hi_data),
      .b_data    (lo_data),
      .we        (inst_we),
      .widx      (fld.dst_idx),
      .wdata     (window),
      .dbg_we    (dbg_we),
      .dbg_widx  (dbg_widx),
      .dbg_wdata (dbg_wdata),
      .dbg_ridx  (dbg_ridx),
      .dbg_rdata (dbg_rdata)
   );

   bytealign_funnel #(.DATA_W(DATA_W)) u_fun (
      .hi_data (hi_data),
      .lo_data (lo_data),
      .offset  (fld.offset),
      .window  (window)
   );

   always_ff @(posedge clk) begin
      if (rst) rsvd_q <= 1'b0;
      else     rsvd_q <= rsvd_hit;
   end
   assign rsvd_flag = rsvd_q;

   logic [2*DATA_W-1:0] chk_dup;
   logic [DATA_W-1:0]   chk_rot;
   assign chk_dup = {hi_data, hi_data} << (8 * fld.offset);
   assign chk_rot = chk_dup[2*DATA_W-1 -: DATA_W];

   assert_foreign_ignored_R1: assert property (@(posedge clk) disable iff (rst)
      (!insn_valid || insn_word[MAJOR_LSB +: OPC_W] != MAJOR_GRP) |-> !inst_we);

   assert_pad_noop_R3: assert property (@(posedge clk) disable iff (rst)
      (insn_word[PAD_LSB +: PAD_W] != '0) |=> !rsvd_flag);

   assert_hi_pass_R6: assert property (@(posedge clk) disable iff (rst)
      (inst_we && fld.offset == '0) |-> (window == hi_data));

   assert_lo_pass_R6: assert property (@(posedge clk) disable iff (rst)
      (inst_we && 32'(fld.offset) == LANES) |-> (window == lo_data));

   assert_same_src_rotate_R8: assert property (@(posedge clk) disable iff (rst)
      (inst_we && fld.hi_idx == fld.lo_idx && fld.offset != '0 && 32'(fld.offset) < LANES)
      |-> (window == chk_rot));

   assert_reserved_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      (hit && fld.pad == '0 && 32'(fld.offset) > LANES) |-> (!inst_we ##1 rsvd_flag));

   assert_dst_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (fld.dst_idx == '0) |-> !inst_we);

endmodule

// File: tb/sim_bytealign_regunit.sv
module sim_bytealign_regunit;

   localparam logic [5:0] MINOR = 6'h2F;
   localparam logic [5:0] MAJOR = 6'b011100;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        insn_valid = 1'b0;
   logic [31:0] insn_word = '0;
   logic        dbg_we = 1'b0;
   logic [3:0]  dbg_widx = '0;
   logic [31:0] dbg_wdata = '0;
   logic [3:0]  dbg_ridx = '0;
   logic [31:0] dbg_rdata;
   logic        rsvd_flag;

   int checks = 0;
   int errors = 0;
   logic [31:0] model [16];

   always #10 clk = ~clk;

   bytealign_regunit u0 (
      .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_word(insn_word),
      .dbg_we(dbg_we), .dbg_widx(dbg_widx), .dbg_wdata(dbg_wdata),
      .dbg_ridx(dbg_ridx), .dbg_rdata(dbg_rdata), .rsvd_flag(rsvd_flag)
   );

   function automatic logic [31:0] mk(input logic [2:0] off, input logic [1:0] pad,
                                      input logic [3:0] lo, input logic [3:0] hi,
                                      input logic [3:0] dst);
      return {MAJOR, off, pad, 3'b000, lo, hi, dst, MINOR};
   endfunction

   function automatic logic [31:0] align(input logic [31:0] hi, input logic [31:0] lo,
                                         input int k);
      logic [63:0] s;
      s = {hi, lo} << (8 * k);
      return s[63:32];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_reg(input string req, input int idx, input logic [31:0] exp);
      dbg_ridx = 4'(idx);
      #1;
      chk(req, dbg_rdata, exp);
   endtask

   task automatic check_all(input string req);
      for (int i = 0; i < 16; i++) check_reg(req, i, model[i]);
   endtask

   task automatic load(input int idx, input logic [31:0] val);
      @(negedge clk);
      dbg_we = 1'b1; dbg_widx = 4'(idx); dbg_wdata = val;
      @(negedge clk);
      dbg_we = 1'b0;
      if (idx != 0) model[idx] = val;
   endtask

   task automatic issue(input logic [31:0] w, input logic v);
      @(negedge clk);
      insn_valid = v; insn_word = w;
      @(negedge clk);
      insn_valid = 1'b0; insn_word = '0;
   endtask

   task automatic t_reset;
      for (int i = 0; i < 16; i++) model[i] = '0;
      check_all("R10 reset clears registers");
      chk("R10 reset clears flag", 32'(rsvd_flag), 32'd0);
   endtask

   task automatic t_load;
      for (int i = 1; i < 16; i++) load(i, 32'h9E3779B9 * i ^ 32'h0F1E2D3C);
      load(0, 32'hDEADBEEF);
      check_all("R11 debug preload");
      check_reg("R4 reg0 stays zero", 0, 32'h0);
   endtask

   task automatic t_offsets;
      logic [31:0] hi, lo;
      model[5] = 32'hA1B2C3D4; model[9] = 32'h15263748;
      load(5, model[5]); load(9, model[9]);
      hi = model[5]; lo = model[9];
      for (int k = 0; k <= 4; k++) begin
         issue(mk(3'(k), 2'b00, 4'd9, 4'd5, 4'd12), 1'b1);
         model[12] = align(hi, lo, k);
         check_reg("R6 window by offset", 12, model[12]);
      end
      issue(mk(3'd0, 2'b00, 4'd9, 4'd5, 4'd12), 1'b1);
      check_reg("R6 offset0 is hi", 12, 32'hA1B2C3D4);
      issue(mk(3'd4, 2'b00, 4'd9, 4'd5, 4'd12), 1'b1);
      check_reg("R6 offset4 is lo", 12, 32'h15263748);
      issue(mk(3'd1, 2'b00, 4'd9, 4'd5, 4'd12), 1'b1);
      check_reg("R7 offset1", 12, 32'hB2C3D415);
      issue(mk(3'd2, 2'b00, 4'd9, 4'd5, 4'd12), 1'b1);
      check_reg("R7 offset2", 12, 32'hC3D41526);
      issue(mk(3'd3, 2'b00, 4'd9, 4'd5, 4'd11), 1'b1);
      model[11] = 32'hD4152637;
      model[12] = 32'hC3D41526;
      check_all("R2 only destination changes");
   endtask

   task automatic t_same;
      model[7] = 32'h80FF0102; load(7, model[7]);
      issue(mk(3'd1, 2'b00, 4'd7, 4'd7, 4'd13), 1'b1);
      check_reg("R8 rotate by 1 byte", 13, 32'hFF010280);
      issue(mk(3'd2, 2'b00, 4'd7, 4'd7, 4'd13), 1'b1);
      check_reg("R8 rotate by 2 bytes", 13, 32'h010280FF);
      issue(mk(3'd3, 2'b00, 4'd7, 4'd7, 4'd13), 1'b1);
      check_reg("R8 rotate by 3 bytes", 13, 32'h0280FF01);
      model[13] = 32'h0280FF01;
   endtask

   task automatic t_zero_src;
      issue(mk(3'd2, 2'b00, 4'd9, 4'd0, 4'd14), 1'b1);
      check_reg("R5 zero hi source", 14, 32'h00001526);
      issue(mk(3'd1, 2'b00, 4'd0, 4'd5, 4'd14), 1'b1);
      check_reg("R5 zero lo source", 14, 32'hB2C3D400);
      issue(mk(3'd3, 2'b00, 4'd0, 4'd0, 4'd14), 1'b1);
      check_reg("R5 both sources zero", 14, 32'h0);
      model[14] = 32'h0;
   endtask

   task automatic t_dst0;
      issue(mk(3'd1, 2'b00, 4'd9, 4'd5, 4'd0), 1'b1);
      check_all("R4 dest zero writes nothing");
   endtask

   task automatic t_pad;
      for (int p = 1; p < 4; p++) begin
         issue(mk(3'd1, 2'(p), 4'd9, 4'd5, 4'd3), 1'b1);
         chk("R3 pad no flag", 32'(rsvd_flag), 32'd0);
         check_all("R3 pad is no-op");
      end
   endtask

   task automatic t_reserved;
      for (int k = 5; k < 8; k++) begin
         issue(mk(3'(k), 2'b00, 4'd9, 4'd5, 4'd3), 1'b1);
         chk("R9 flag after reserved offset", 32'(rsvd_flag), 32'd1);
         @(negedge clk);
         chk("R9 flag lasts one cycle", 32'(rsvd_flag), 32'd0);
         check_all("R9 reserved writes nothing");
      end
   endtask

   task automatic t_foreign;
      logic [31:0] w;
      w = mk(3'd2, 2'b00, 4'd9, 4'd5, 4'd3);
      issue({6'b011101, w[25:0]}, 1'b1);
      check_all("R1 wrong major ignored");
      issue({w[31:6], 6'h2E}, 1'b1);
      check_all("R1 wrong minor ignored");
      issue(w, 1'b0);
      check_all("R1 valid low ignored");
      chk("R1 no flag", 32'(rsvd_flag), 32'd0);
   endtask

   task automatic t_collide;
      @(negedge clk);
      insn_valid = 1'b1; insn_word = mk(3'd0, 2'b00, 4'd9, 4'd5, 4'd6);
      dbg_we = 1'b1; dbg_widx = 4'd6; dbg_wdata = 32'h55555555;
      @(negedge clk);
      insn_valid = 1'b0; dbg_we = 1'b0;
      model[6] = 32'hA1B2C3D4;
      check_reg("R11 instruction wins collision", 6, model[6]);
   endtask

   task automatic t_reset_again;
      issue(mk(3'd6, 2'b00, 4'd9, 4'd5, 4'd3), 1'b1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 16; i++) model[i] = '0;
      check_all("R10 mid-run reset");
      chk("R10 reset clears pending flag", 32'(rsvd_flag), 32'd0);
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_load();
      t_offsets();
      t_same();
      t_zero_src();
      t_dst0();
      t_pad();
      t_reserved();
      t_foreign();
      t_collide();
      t_reset_again();
      finish_run();
   end

endmodule